// File: doc/BRIEF.md
# Serial Flash Status and Write-Guard Unit

This unit is the device-side status register and write-guard of a serial flash. An SPI front end has already turned the serial stream into decoded commands. The unit decides whether each command that changes state is accepted, keeps the status flags, and launches program, erase and status-write cycles toward the internal timer. The timer reports back through a busy line. The unit holds the busy flag until the timer finishes, then clears the write-enable latch.

Two guards can block a command that would otherwise be accepted:
- A two-bit protect level covers a growing slice of the array, and program or erase commands aimed at that slice are refused.
- A lock bit together with a low write-protect pin freezes the nonvolatile status bits.

A status read is answered at any time, including while a cycle runs. The nonvolatile bits are modelled as ordinary registers.

Top module: `flash_status_ctl`

## Requirements
- R1: After reset the status byte is 0x00, and rd_valid and cyc_start are low.
- R2: A command is taken only when cmd_valid is 1 and cs_n is 0. Command codes are: 0 none, 1 write enable, 2 write disable, 3 read status, 4 write status, 5 program, 6 sector erase, 7 bulk erase. With cs_n high, a command has no effect.
- R3: The status byte layout is: bit 0 busy flag, bit 1 write-enable latch, bits 3:2 protect level, bit 7 lock bit. Bits 6:4 always read 0.
- R4: A taken write-enable sets the latch and a taken write-disable clears it. Both show in the cycle after the command.
- R5: Commands 4 to 7 are ignored unless the write-enable latch is 1.
- R6: An accepted command 4 to 7 gives a one-cycle cyc_start pulse in the next cycle, and sets the busy flag at the same time. cyc_kind is 0 for write status, 1 for program, 2 for sector erase and 3 for bulk erase.
- R7: The busy flag stays 1 until the cycle after cycle_busy falls. In that cycle both the busy flag and the write-enable latch clear.
- R8: While the busy flag is 1, every command except read status is ignored.
- R9: A taken read-status command gives rd_valid one cycle later, with rd_data equal to the status byte in the command cycle. This also holds while busy.
- R10: An accepted write status loads the protect level from cmd_data[3:2] and the lock bit from cmd_data[7]. The other data bits are ignored.
- R11: While the lock bit is 1 and wp_n is 0, a write-status command is ignored entirely: it starts no cycle and changes no flag.
- R12: The protected region depends on the protect level. Level 01 protects addresses whose two top bits are 11. Level 10 protects addresses whose top bit is 1. Level 11 protects everything. Program or sector erase to a protected address is ignored. Bulk erase is ignored unless the level is 00.
- R13: standby is 1 exactly when cs_n is high and the busy flag is 0. A running cycle keeps going when cs_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| cmd_valid | input | 1 | Decoded command present |
| cmd | input | 3 | Command code |
| cmd_addr | input | ADDR_W | Target address for program and sector erase |
| cmd_data | input | 8 | New status byte for write status |
| cycle_busy | input | 1 | Internal timer is running a cycle |
| status | output | 8 | Status byte |
| rd_valid | output | 1 | Read-status answer valid |
| rd_data | output | 8 | Status byte captured for a read |
| cyc_start | output | 1 | One-cycle pulse launching a timed cycle |
| cyc_kind | output | 2 | Kind of cycle launched |
| standby | output | 1 | Device may drop to standby |

## Verification
Every registered result is due exactly one clock edge after the cycle in which its command is presented: latch changes, protect-level and lock updates, cyc_start and cyc_kind, rd_valid and rd_data. The end of a cycle is also due one edge after cycle_busy falls. standby follows cs_n combinationally in the same cycle. The bench drives each input set on a falling edge. It advances its reference model by one edge and compares every output on the next falling edge, so each result is sampled in the cycle it is due. The bench's timer model raises cycle_busy in the cycle after cyc_start and holds it for one to four cycles.

// File: rtl/flash_sr_pkg.sv
package flash_sr_pkg;
   typedef enum logic [2:0] {
      CMD_NONE   = 3'd0,
      CMD_WEN    = 3'd1,
      CMD_WDIS   = 3'd2,
      CMD_RDST   = 3'd3,
      CMD_WRST   = 3'd4,
      CMD_PROG   = 3'd5,
      CMD_SERASE = 3'd6,
      CMD_BERASE = 3'd7
   } sr_cmd_e;

   typedef enum logic [1:0] {
      KIND_WRST   = 2'd0,
      KIND_PROG   = 2'd1,
      KIND_SERASE = 2'd2,
      KIND_BERASE = 2'd3
   } cyc_kind_e;
endpackage

// File: rtl/sr_region_guard.sv
module sr_region_guard #(
   parameter int FROM_TOP = 1
) (
   input  logic [1:0] level,
   input  logic [1:0] addr_hi,
   output logic       addr_locked,
   output logic       any_locked
);
   logic quarter_hit;
   logic half_hit;

   generate
      if (FROM_TOP != 0 && FROM_TOP != 1) begin : g_bad_side
         $error("sr_region_guard: FROM_TOP must be 0 or 1");
      end
      if (FROM_TOP == 1) begin : g_top
         assign quarter_hit = (addr_hi == 2'b11);
         assign half_hit    = addr_hi[1];
      end else begin : g_bottom
         assign quarter_hit = (addr_hi == 2'b00);
         assign half_hit    = ~addr_hi[1];
      end
   endgenerate

   always_comb begin
      unique case (level)
         2'b00:   addr_locked = 1'b0;
         2'b01:   addr_locked = quarter_hit;
         2'b10:   addr_locked = half_hit;
         default: addr_locked = 1'b1;
      endcase
   end

   assign any_locked = (level != 2'b00);
endmodule

// File: rtl/sr_cycle_track.sv
module sr_cycle_track (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   input  logic timer_busy,
   output logic in_cycle,
   output logic finish
);
   logic busy_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_d <= 1'b0;
      else        busy_d <= timer_busy;
   end

   assign finish = busy_d & ~timer_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      in_cycle <= 1'b0;
      else if (finish) in_cycle <= 1'b0;
      else if (launch) in_cycle <= 1'b1;
   end
endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
   import flash_sr_pkg::*;
#(
   parameter int ADDR_W   = 18,
   parameter int FROM_TOP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              wp_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   input  logic              cycle_busy,
   output logic [7:0]        status,
   output logic              rd_valid,
   output logic [7:0]        rd_data,
   output logic              cyc_start,
   output logic [1:0]        cyc_kind,
   output logic              standby
);
   localparam int HI = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("flash_status_ctl: ADDR_W must be at least 2");
      end
   endgenerate

   sr_cmd_e    op;
   logic       take, hw_lock, wip, done;
   logic       wel, lock_bit;
   logic [1:0] level;
   logic       addr_locked, any_locked;
   logic       accept;
   cyc_kind_e  kind_nxt;
   logic       unused_bits;

   assign op          = sr_cmd_e'(cmd);
   assign take        = cmd_valid & ~cs_n;
   assign hw_lock     = lock_bit & ~wp_n;
   assign unused_bits = ^{cmd_data[6:4], cmd_data[1:0], cmd_addr[HI-2:0]};

   sr_region_guard #(.FROM_TOP(FROM_TOP)) u_guard (
      .level       (level),
      .addr_hi     (cmd_addr[HI -: 2]),
      .addr_locked (addr_locked),
      .any_locked  (any_locked)
   );

   sr_cycle_track u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (accept),
      .timer_busy (cycle_busy),
      .in_cycle   (wip),
      .finish     (done)
   );

   always_comb begin
      accept   = 1'b0;
      kind_nxt = KIND_WRST;
      if (take && !wip && wel) begin
         unique case (op)
            CMD_WRST: begin
               accept   = ~hw_lock;
               kind_nxt = KIND_WRST;
            end
            CMD_PROG: begin
               accept   = ~addr_locked;
               kind_nxt = KIND_PROG;
            end
            CMD_SERASE: begin
               accept   = ~addr_locked;
               kind_nxt = KIND_SERASE;
            end
            CMD_BERASE: begin
               accept   = ~any_locked;
               kind_nxt = KIND_BERASE;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel <= 1'b0;
      end else if (done) begin
         wel <= 1'b0;
      end else if (take && !wip) begin
         if (op == CMD_WEN)       wel <= 1'b1;
         else if (op == CMD_WDIS) wel <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level    <= 2'b00;
         lock_bit <= 1'b0;
      end else if (accept && op == CMD_WRST) begin
         level    <= cmd_data[3:2];
         lock_bit <= cmd_data[7];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_start <= 1'b0;
         cyc_kind  <= KIND_WRST;
         rd_valid  <= 1'b0;
         rd_data   <= 8'h00;
      end else begin
         cyc_start <= accept;
         cyc_kind  <= kind_nxt;
         rd_valid  <= take && (op == CMD_RDST);
         rd_data   <= status;
      end
   end

   assign status  = {lock_bit, 3'b000, level, wel, wip};
   assign standby = cs_n & ~wip;
endmodule

// File: rtl/flash_status_chk.sv
module flash_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_n,
   input logic       wp_n,
   input logic       cmd_valid,
   input logic [2:0] cmd,
   input logic       cycle_busy,
   input logic [7:0] status,
   input logic       rd_valid,
   input logic       cyc_start,
   input logic       standby
);
   // R7
   busy_covered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cycle_busy |-> status[0]);

   // R3
   zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[6:4] == 3'b000);

   // R11
   hw_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status[7] && !wp_n) |=> status[7:2] == $past(status[7:2]));

   // R5
   start_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |-> $past(status[1]));

   // R8
   start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |-> !$past(status[0]));

   // R4
   wdis_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cs_n && cmd == 3'd2 && !status[0]) |=> !status[1]);

   // R9
   read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cs_n && cmd == 3'd3) |=> rd_valid);

   // R13
   busy_no_standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status[0] |-> !standby);
endmodule

bind flash_status_ctl flash_status_chk u_chk (.*);

// File: tb/tb_flash_status_ctl.sv
module tb_flash_status_ctl;
   localparam int AW = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cs_n = 1'b1, wp_n = 1'b1, cmd_valid = 1'b0, cycle_busy = 1'b0;
   logic [2:0]    cmd = 3'd0;
   logic [AW-1:0] cmd_addr = '0;
   logic [7:0]    cmd_data = 8'h00;
   logic [7:0]    status, rd_data;
   logic          rd_valid, cyc_start, standby;
   logic [1:0]    cyc_kind;

   int checks = 0, errors = 0, tcnt = 0;
   bit finished = 0;

   logic       m_wip = 0, m_wel = 0, m_srwd = 0, m_busy_d = 0;
   logic [1:0] m_bp = 0, m_kind = 0;
   logic       m_start = 0, m_rdv = 0;
   logic [7:0] m_rdd = 0;

   always #5 clk = ~clk;

   flash_status_ctl #(.ADDR_W(AW)) dut (.*);

   function automatic logic [7:0] exp_sr();
      return {m_srwd, 3'b000, m_bp, m_wel, m_wip};
   endfunction

   function automatic logic locked(input logic [1:0] bp, input logic [AW-1:0] a);
      case (bp)
         2'b00:   return 1'b0;
         2'b01:   return a[AW-1:AW-2] == 2'b11;
         2'b10:   return a[AW-1];
         default: return 1'b1;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      logic take, done;
      take  = cmd_valid & ~cs_n;
      done  = m_busy_d & ~cycle_busy;
      m_rdv = take && cmd == 3'd3;
      m_rdd = exp_sr();
      m_start = 0;
      if (done) begin
         m_wip = 0; m_wel = 0;
      end else if (take && !m_wip) begin
         case (cmd)
            3'd1: m_wel = 1;
            3'd2: m_wel = 0;
            3'd4: if (m_wel && !(m_srwd && !wp_n)) begin
               m_bp = cmd_data[3:2]; m_srwd = cmd_data[7];
               m_start = 1; m_kind = 2'd0; m_wip = 1;
            end
            3'd5, 3'd6: if (m_wel && !locked(m_bp, cmd_addr)) begin
               m_start = 1; m_kind = 2'(cmd - 3'd4); m_wip = 1;
            end
            3'd7: if (m_wel && m_bp == 2'b00) begin
               m_start = 1; m_kind = 2'd3; m_wip = 1;
            end
            default: ;
         endcase
      end
      m_busy_d = cycle_busy;
   endtask

   // Drives one input set at a falling edge, advances one clock edge, compares at the next falling edge.
   task automatic step(input logic v, input logic [2:0] c, input logic [AW-1:0] a,
                       input logic [7:0] d, input logic wp, input logic cs);
      cmd_valid = v; cmd = c; cmd_addr = a; cmd_data = d; wp_n = wp; cs_n = cs;
      cycle_busy = (tcnt > 0);
      model_edge();
      @(posedge clk);
      @(negedge clk);
      chk("R7 busy flag", status[0], m_wip);
      chk("R4 write-enable latch", status[1], m_wel);
      chk("R10 protect level", status[3:2], m_bp);
      chk("R3 zero bits", status[6:4], 3'b000);
      chk("R11 lock bit", status[7], m_srwd);
      chk("R6 cyc_start", cyc_start, m_start);
      if (m_start) chk("R6 cyc_kind", cyc_kind, m_kind);
      chk("R9 rd_valid", rd_valid, m_rdv);
      if (m_rdv) chk("R9 rd_data", rd_data, m_rdd);
      chk("R13 standby", standby, cs_n & ~m_wip);
      if (tcnt > 0) tcnt--;
      if (m_start) tcnt = 1 + int'($urandom % 4);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 3'd0, '0, 8'h00, 1, 0);
   endtask

   task automatic drain();
      for (int i = 0; i < 20 && status[0]; i++) idle(1);
      idle(1);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 reset state
      chk("R1 status after reset", status, 8'h00);
      chk("R1 rd_valid after reset", rd_valid, 1'b0);
      chk("R1 cyc_start after reset", cyc_start, 1'b0);
      rst_n = 1'b1;
      idle(1);
      // R2 command with chip select high is ignored
      step(1, 3'd1, '0, 8'h00, 1, 1);
      chk("R2 write enable with cs_n high", status[1], 1'b0);
      // R5 program without latch is ignored
      step(1, 3'd5, '0, 8'h00, 1, 0);
      chk("R5 program without latch", cyc_start, 1'b0);
      // R10 write status with all data bits set
      step(1, 3'd1, '0, 8'h00, 1, 0);
      step(1, 3'd4, '0, 8'hFF, 1, 0);
      drain();
      chk("R10 status after write 0xFF", status, 8'h8C);
      // R11 hardware protected write status is refused
      step(1, 3'd1, '0, 8'h00, 0, 0);
      step(1, 3'd4, '0, 8'h00, 0, 0);
      chk("R11 locked write status", status, 8'h8E);
      chk("R11 no cycle launched", cyc_start, 1'b0);
      step(1, 3'd4, '0, 8'h04, 1, 0);
      drain();
      chk("R10 level 01 loaded", status, 8'h04);
      // R12 top quarter protected, low address open
      step(1, 3'd1, '0, 8'h00, 1, 0);
      step(1, 3'd5, 18'h3_0010, 8'h00, 1, 0);
      chk("R12 program to protected quarter", cyc_start, 1'b0);
      step(1, 3'd7, '0, 8'h00, 1, 0);
      chk("R12 bulk erase with level 01", cyc_start, 1'b0);
      step(1, 3'd6, 18'h2_0000, 8'h00, 1, 0);
      chk("R12 sector erase outside quarter", cyc_start, 1'b1);
      // R8 and R9 during the cycle; R13 cycle survives cs_n high
      step(1, 3'd2, '0, 8'h00, 1, 0);
      chk("R8 write disable ignored while busy", status[1], 1'b1);
      step(1, 3'd3, '0, 8'h00, 1, 0);
      chk("R9 read while busy", rd_data[0], 1'b1);
      step(0, 3'd0, '0, 8'h00, 1, 1);
      chk("R13 no standby while busy", standby, 1'b0);
      for (int i = 0; i < 20 && status[0]; i++) step(0, 3'd0, '0, 8'h00, 1, 1);
      chk("R13 standby after cycle", standby, 1'b1);
      chk("R7 latch cleared at end", status[1], 1'b0);
      // Random phase
      for (int i = 0; i < 4000; i++) begin
         logic [2:0] c;
         c = ($urandom % 3 == 0) ? 3'd1 : 3'($urandom);
         step(($urandom % 10) < 7, c, AW'($urandom), 8'($urandom),
              ($urandom % 5) != 0, ($urandom % 10) == 0);
      end
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule